// File: doc/BRIEF.md
# Monochrome STN Panel Timing Generator

This block drives a single-scan monochrome STN panel from an image kept in memory. It reads the image in 16-bit halfwords through a plain read port with a fixed one-cycle latency. Each pixel clock carries four panel pixels on a 4-bit data bus. Around that data it generates the pixel clock, a line clock after every line, a frame sync pulse covering the first line, and an AC bias level that flips once per frame.

Software-visible settings arrive as plain inputs: the panel width in units of 16 pixels, the stored depth per pixel, the image base address and the number of lines per frame. They are captured while the block is disabled and again at every frame boundary, so a change made during a frame is applied to the next frame. Each pixel slot lasts `PCLK_DIV` system clocks (at least 4). A line is width/4 data slots followed by one line-clock slot.

Top module: `lcd_stn_timing`

## Requirements
- R1: While reset is held, and after it, until `enable` is raised, `lcd_pclk`, `lcd_lclk`, `lcd_frm`, `lcd_acb`, `lcd_data` and `mem_req` are all 0.
- R2: Every line gives exactly width/4 pixel clock pulses, and then one line clock pulse. Here width = 16 × `cfg_width16` pixels. `lcd_pclk` and `lcd_lclk` are never high at the same time.
- R3: At each pixel clock pulse, bit k of `lcd_data` is the most significant bit of pixel 4n+k of the line, where n counts the pulses since the line clock. Within a halfword, the pixel with the lowest index sits in the least significant bits. The halfword at the lower address is shown first. `lcd_data` holds steady while `lcd_pclk` is high.
- R4: `cfg_bpp` selects the stored depth: 0 means 1 bit, 1 means 2 bits, and both 2 and 3 mean 4 bits.
- R5: Each read is a one-cycle `mem_req` pulse. `mem_rdata` must be valid in the following cycle. Reads fetch consecutive halfwords, with `mem_addr` a byte address that rises by 2 per read. One frame therefore takes lines × width × depth / 16 reads.
- R6: At each frame start, the read address reloads from `cfg_base` with bit 0 forced to 0. Addresses wrap modulo 2^ADDR_W.
- R7: A frame has `cfg_lines` lines (1 or more). `lcd_frm` is high throughout the first line of each frame and low during the others.
- R8: `lcd_acb` toggles exactly once per frame, in the cycle after the line clock pulse of the last line. It keeps its level while the block is disabled.
- R9: The width, depth, base and line count are captured while `enable` is low and at each frame boundary. A change made inside a frame first affects the next frame.
- R10: Two clock edges after `enable` is sampled low, `lcd_pclk`, `lcd_lclk`, `lcd_frm`, `lcd_data` and `mem_req` are 0.
- R11: Panel widths from 32 to 1024 pixels (`cfg_width16` 2 to 64) are supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the panel timing; low parks it |
| cfg_width16 | input | WID_W | Panel width in units of 16 pixels |
| cfg_bpp | input | 2 | Stored bits per pixel code |
| cfg_base | input | ADDR_W | Image base byte address |
| cfg_lines | input | LINE_W | Lines per frame |
| mem_req | output | 1 | Halfword read request pulse |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| lcd_pclk | output | 1 | Pixel clock to the panel |
| lcd_lclk | output | 1 | Line clock to the panel |
| lcd_data | output | 4 | Four pixels per pixel clock |
| lcd_frm | output | 1 | Frame sync, high during the first line |
| lcd_acb | output | 1 | AC bias level |

## Verification
With the default four-cycle slot, a read goes out in the first cycle of a slot and its data returns in the second. The data reaches `lcd_data` after the edge that ends that cycle, and `lcd_pclk` is high during the fourth cycle. The line clock follows in the same position of the slot after the last data slot, and `lcd_acb` flips one cycle after that line clock pulse. The bench samples on the falling clock edge and captures `lcd_data` when it sees `lcd_pclk` fall, so the value it checks is the one presented for that pulse. It checks the disable response exactly two edges after `enable` drops, and it stops counting reads as the next frame begins.

// File: rtl/lcd_stn_pkg.sv
// Shared constants and helpers for the STN timing generator.
// Assumes 16-bit memory words and four panel pixels per pixel clock.
package lcd_stn_pkg;

    localparam int WORD_W       = 16;
    localparam int PIX_PER_PCLK = 4;

    // Pixel-clock slots served by one halfword for a depth code.
    function automatic logic [2:0] slots_per_word(input logic [1:0] code);
        unique case (code)
            2'd0:    return 3'd4;
            2'd1:    return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    // MSB of each of the four pixels in slot 'sub' of halfword 'w'.
    function automatic logic [3:0] panel_nibble(input logic [WORD_W-1:0] w,
                                                input logic [1:0]        sub,
                                                input logic [1:0]        code);
        logic [3:0] n;
        logic [3:0] idx;
        for (int p = 0; p < PIX_PER_PCLK; p++) begin
            unique case (code)
                2'd0:    idx = {sub, 2'(p)};
                2'd1:    idx = {sub[0], 2'(p), 1'b1};
                default: idx = {2'(p), 2'b11};
            endcase
            n[p] = w[idx];
        end
        return n;
    endfunction

endpackage

// File: rtl/lcd_phase_gen.sv
// Slot phase counter. Each pixel slot lasts DIV clocks; strobes mark the
// fetch, load, clock-rise and slot-end phases. Assumes DIV >= 4.
module lcd_phase_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic st_fetch,
    output logic st_load,
    output logic st_rise,
    output logic st_end
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] phase_q;

    // Advance the phase within a slot, parked at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)               phase_q <= '0;
        else if (phase_q == PW'(DIV - 1)) phase_q <= '0;
        else                              phase_q <= phase_q + PW'(1);
    end

    assign st_fetch = run && (phase_q == PW'(0));
    assign st_load  = run && (phase_q == PW'(1));
    assign st_rise  = run && (phase_q == PW'(2));
    assign st_end   = run && (phase_q == PW'(DIV - 1));
endmodule

// File: rtl/lcd_raster.sv
// Slot and line counters plus the panel clock, frame sync and AC bias
// outputs. Width and line count are shadowed while stopped and at frame end.
module lcd_raster #(
    parameter int WID_W  = 7,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              st_rise,
    input  logic              st_end,
    input  logic [WID_W-1:0]  cfg_width16,
    input  logic [LINE_W-1:0] cfg_lines,
    output logic              in_data,
    output logic              frame_wrap,
    output logic              pclk,
    output logic              lclk,
    output logic              frm,
    output logic              acb
);
    localparam int SLOT_W = WID_W + 2;

    logic [WID_W-1:0]  width_s;
    logic [LINE_W-1:0] lines_s;
    logic [SLOT_W-1:0] slot_q;
    logic [LINE_W-1:0] line_q;
    logic [SLOT_W-1:0] n_slots;
    logic              last_line;
    logic              in_line;

    assign n_slots    = {width_s, 2'b00};
    assign in_data    = (slot_q != n_slots);
    assign in_line    = !in_data;
    assign last_line  = (line_q == lines_s - LINE_W'(1));
    assign frame_wrap = st_end && in_line && last_line;
    assign frm        = run && (line_q == '0);

    // Capture geometry while stopped and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_s <= '0;
            lines_s <= '0;
        end else if (!run || frame_wrap) begin
            width_s <= cfg_width16;
            lines_s <= cfg_lines;
        end
    end

    // Step through data slots, the line-clock slot and the lines of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            slot_q <= '0;
            line_q <= '0;
        end else if (st_end) begin
            if (in_line) begin
                slot_q <= '0;
                line_q <= last_line ? '0 : line_q + LINE_W'(1);
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end
    end

    // Pixel and line clock pulses, high from the rise phase to slot end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pclk <= 1'b0;
            lclk <= 1'b0;
        end else if (st_rise) begin
            pclk <= in_data;
            lclk <= in_line;
        end else if (st_end) begin
            pclk <= 1'b0;
            lclk <= 1'b0;
        end
    end

    // AC bias flips once per frame and holds while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)          acb <= 1'b0;
        else if (frame_wrap) acb <= !acb;
    end
endmodule

// File: rtl/lcd_pixel_fetch.sv
// Reads halfwords from the image and turns them into 4-pixel panel nibbles.
// Assumes a fixed one-cycle read latency and lines that fill whole halfwords.
module lcd_pixel_fetch
    import lcd_stn_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              st_fetch,
    input  logic              st_load,
    input  logic              st_end,
    input  logic              in_data,
    input  logic              frame_wrap,
    input  logic [1:0]        cfg_bpp,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        data
);
    logic [1:0]        bpp_s;
    logic [1:0]        sub_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] word_q;
    logic [2:0]        spw;
    logic              word_start;
    logic              reload;

    assign spw        = slots_per_word(bpp_s);
    assign word_start = (sub_q == 2'd0);
    assign reload     = !run || frame_wrap;
    assign mem_req    = st_fetch && in_data && word_start;
    assign mem_addr   = addr_q;

    // Capture the depth code while stopped and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      bpp_s <= 2'd0;
        else if (reload) bpp_s <= cfg_bpp;
    end

    // Reload the read address per frame, then step one halfword per read.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (reload)  addr_q <= cfg_base & ~ADDR_W'(1);
        else if (mem_req) addr_q <= addr_q + ADDR_W'(2);
    end

    // Track which slot of the current halfword is being shown.
    always_ff @(posedge clk) begin
        if (!rst_n || reload)
            sub_q <= 2'd0;
        else if (st_end && in_data)
            sub_q <= ({1'b0, sub_q} == spw - 3'd1) ? 2'd0 : sub_q + 2'd1;
    end

    // Hold the returned halfword for the later slots that use it.
    always_ff @(posedge clk) begin
        if (!rst_n)                           word_q <= '0;
        else if (st_load && in_data && word_start) word_q <= mem_rdata;
    end

    // Present the nibble for this slot one cycle after the read returns.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            data <= 4'd0;
        else if (st_load && in_data)
            data <= panel_nibble(word_start ? mem_rdata : word_q, sub_q, bpp_s);
    end
endmodule

// File: rtl/lcd_stn_timing.sv
// Top of the monochrome STN timing generator: ties the slot phase counter,
// the raster counters and the pixel fetch path. Assumes PCLK_DIV >= 4.
module lcd_stn_timing #(
    parameter int ADDR_W   = 17,
    parameter int WID_W    = 7,
    parameter int LINE_W   = 10,
    parameter int PCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [WID_W-1:0]  cfg_width16,
    input  logic [1:0]        cfg_bpp,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LINE_W-1:0] cfg_lines,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [15:0]       mem_rdata,
    output logic              lcd_pclk,
    output logic              lcd_lclk,
    output logic [3:0]        lcd_data,
    output logic              lcd_frm,
    output logic              lcd_acb
);
    logic run_q;
    logic st_fetch, st_load, st_rise, st_end;
    logic in_data, frame_wrap;

    // Register the enable so every stage starts and stops together.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= enable;
    end

    lcd_phase_gen #(.DIV(PCLK_DIV)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .st_fetch (st_fetch),
        .st_load  (st_load),
        .st_rise  (st_rise),
        .st_end   (st_end)
    );

    lcd_raster #(.WID_W(WID_W), .LINE_W(LINE_W)) u_raster (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_q),
        .st_rise     (st_rise),
        .st_end      (st_end),
        .cfg_width16 (cfg_width16),
        .cfg_lines   (cfg_lines),
        .in_data     (in_data),
        .frame_wrap  (frame_wrap),
        .pclk        (lcd_pclk),
        .lclk        (lcd_lclk),
        .frm         (lcd_frm),
        .acb         (lcd_acb)
    );

    lcd_pixel_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .st_fetch   (st_fetch),
        .st_load    (st_load),
        .st_end     (st_end),
        .in_data    (in_data),
        .frame_wrap (frame_wrap),
        .cfg_bpp    (cfg_bpp),
        .cfg_base   (cfg_base),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .data       (lcd_data)
    );
endmodule

// File: rtl/lcd_stn_checker.sv
// Protocol checks on the panel and memory ports of lcd_stn_timing.
module lcd_stn_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       lcd_pclk,
    input logic       lcd_lclk,
    input logic       lcd_frm,
    input logic       lcd_acb,
    input logic [3:0] lcd_data,
    input logic       mem_req
);
    // R2: pixel and line clocks never overlap.
    a_r2_clocks_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(lcd_pclk && lcd_lclk));

    // R3: data does not move while the pixel clock is high.
    a_r3_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_pclk |-> $stable(lcd_data));

    // R5: a read request lasts a single cycle.
    a_r5_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R8: the AC bias only moves right after a line clock pulse.
    a_r8_acb_after_lclk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_acb != $past(lcd_acb)) |-> $past(lcd_lclk));

    // R10: two edges after enable is seen low the panel is quiet.
    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(enable) && !$past(enable, 2)) |->
        (!lcd_pclk && !lcd_lclk && !lcd_frm && lcd_data == 4'd0 && !mem_req));
endmodule

bind lcd_stn_timing lcd_stn_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .lcd_pclk (lcd_pclk),
    .lcd_lclk (lcd_lclk),
    .lcd_frm  (lcd_frm),
    .lcd_acb  (lcd_acb),
    .lcd_data (lcd_data),
    .mem_req  (mem_req)
);

// File: tb/tb_lcd_stn_timing.sv
// Directed bench: one task per scenario, a negedge monitor that rebuilds
// the expected panel stream from the image pattern and the settings.
module tb_lcd_stn_timing;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [6:0]  cfg_width16 = 7'd2;
    logic [1:0]  cfg_bpp = 2'd0;
    logic [16:0] cfg_base = '0;
    logic [9:0]  cfg_lines = 10'd1;
    logic        mem_req;
    logic [16:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        lcd_pclk, lcd_lclk, lcd_frm, lcd_acb;
    logic [3:0]  lcd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lcd_stn_timing dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_width16(cfg_width16), .cfg_bpp(cfg_bpp),
        .cfg_base(cfg_base), .cfg_lines(cfg_lines),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .lcd_pclk(lcd_pclk), .lcd_lclk(lcd_lclk), .lcd_data(lcd_data),
        .lcd_frm(lcd_frm), .lcd_acb(lcd_acb)
    );

    function automatic logic [15:0] img(input int hw);
        logic [15:0] i;
        i = 16'(hw);
        return 16'(i * 16'h9E37) ^ 16'h5A3C;
    endfunction

    // Memory model: one-cycle read latency (R5).
    always @(posedge clk) if (mem_req) mem_rdata <= img(int'(mem_addr >> 1));

    function automatic int depth(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    // Expected nibble for pixels px..px+3 of line ln (R3, R4, R6).
    function automatic logic [3:0] exp_nib(input int base, input int ln,
                                           input int px, input int w, input int b);
        logic [3:0]  r;
        logic [15:0] h;
        for (int p = 0; p < 4; p++) begin
            int bo = (ln * w + px + p) * b;
            int hw = ((base >> 1) + bo / 16) % 65536;
            h = img(hw);
            r[p] = h[bo % 16 + b - 1];
        end
        return r;
    endfunction

    // Monitor state
    logic clr_req = 1'b0, clr_seen = 1'b0, mon_on = 1'b0;
    int   tgt = 0;
    logic p_prev = 1'b0, l_prev = 1'b0, m_prev = 1'b0;
    int   px, ln, frames, lclks, reads, toggles, e_data, e_len, e_frm, e_m;
    int   w_cur, b_cur, base_cur, l_cur;

    always @(negedge clk) begin
        if (clr_req != clr_seen) begin
            clr_seen = clr_req;
            px = 0; ln = 0; frames = 0; lclks = 0; reads = 0; toggles = 0;
            e_data = 0; e_len = 0; e_frm = 0; e_m = 0;
            w_cur = int'(cfg_width16) * 16; b_cur = depth(cfg_bpp);
            base_cur = int'(cfg_base) & ~1; l_cur = int'(cfg_lines);
        end else if (mon_on) begin
            if (mem_req && frames < tgt) reads++;
            if (!lcd_pclk && p_prev) begin
                if (lcd_data !== exp_nib(base_cur, ln, px, w_cur, b_cur)) e_data++;
                if (lcd_frm !== (ln == 0)) e_frm++;
                px += 4;
            end
            if (lcd_lclk && !l_prev) begin
                if (px != w_cur) e_len++;
                px = 0; lclks++; ln++;
                if (ln == l_cur) begin
                    ln = 0; frames++;
                    w_cur = int'(cfg_width16) * 16; b_cur = depth(cfg_bpp);
                    base_cur = int'(cfg_base) & ~1; l_cur = int'(cfg_lines);
                end
            end
            if (lcd_acb !== m_prev) begin
                toggles++;
                if (ln != 0 || px != 0) e_m++;
            end
        end
        p_prev = lcd_pclk; l_prev = lcd_lclk; m_prev = lcd_acb;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start(input int w16, input int code, input int base,
                         input int lines, input int nfr);
        @(negedge clk);
        cfg_width16 = 7'(w16); cfg_bpp = 2'(code);
        cfg_base = 17'(base); cfg_lines = 10'(lines);
        tgt = nfr; clr_req = ~clr_req;
        repeat (2) @(negedge clk);
        mon_on = 1'b1; enable = 1'b1;
    endtask

    task automatic wait_frames(input int nfr);
        int g = 0;
        while (toggles < nfr && g < 40000) begin @(negedge clk); g++; end
        @(negedge clk);
        mon_on = 1'b0;
    endtask

    // R10: quiet two edges after enable drops; R8: bias level held.
    task automatic stop_and_check(input string tag);
        logic acb_before;
        @(negedge clk);
        acb_before = lcd_acb;
        enable = 1'b0;
        repeat (2) @(negedge clk);
        chk({"R10 pclk/lclk/frm/req after disable ", tag},
            int'({lcd_pclk, lcd_lclk, lcd_frm, mem_req}), 0);
        chk({"R10 data after disable ", tag}, int'(lcd_data), 0);
        repeat (8) @(negedge clk);
        chk({"R8 acb held while disabled ", tag}, int'(lcd_acb), int'(acb_before));
    endtask

    task automatic run_case(input string tag, input int w16, input int code,
                            input int base, input int lines, input int nfr);
        start(w16, code, base, lines, nfr);
        wait_frames(nfr);
        chk({"R3 data mismatches ", tag}, e_data, 0);
        chk({"R2 R11 line length errors ", tag}, e_len, 0);
        chk({"R7 frame sync errors ", tag}, e_frm, 0);
        chk({"R7 line pulses ", tag}, lclks, nfr * lines);
        chk({"R8 acb toggles ", tag}, toggles, nfr);
        chk({"R8 acb placement ", tag}, e_m, 0);
        chk({"R5 read count ", tag}, reads, nfr * lines * w16 * depth(2'(code)));
        stop_and_check(tag);
    endtask

    // R1: reset state.
    task automatic t_reset;
        repeat (4) @(negedge clk);
        chk("R1 clocks/frm/acb in reset",
            int'({lcd_pclk, lcd_lclk, lcd_frm, lcd_acb}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 data while idle", int'(lcd_data), 0);
        chk("R1 outputs while idle",
            int'({lcd_pclk, lcd_lclk, lcd_frm, lcd_acb, mem_req}), 0);
    endtask

    // R9: mid-frame setting change lands on the next frame.
    task automatic t_defer;
        start(2, 0, 'h40, 2, 2);
        repeat (30) @(negedge clk);
        cfg_width16 = 7'd4; cfg_bpp = 2'd1; cfg_base = 17'h800; cfg_lines = 10'd3;
        wait_frames(2);
        chk("R9 data across the change", e_data, 0);
        chk("R9 line lengths old then new", e_len, 0);
        chk("R9 line pulses 2 then 3", lclks, 5);
        chk("R9 reads 4 then 24", reads, 28);
        chk("R9 frame sync", e_frm, 0);
        stop_and_check("defer");
    endtask

    initial begin
        t_reset();
        run_case("1bpp w32 odd base", 2, 0, 'h0101, 4, 2);    // R6 bit0 ignored
        run_case("2bpp w64 wrap", 4, 1, 'h1FFF0, 3, 2);       // R6 wrap
        run_case("4bpp w1024", 64, 2, 'h2000, 2, 1);          // R11 max width
        run_case("code3 w48 one line", 3, 3, 'h0, 1, 3);      // R4 code 3
        t_defer();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end
endmodule